// File: doc/BRIEF.md
# Linked-Seek Queue Pointer Bank

This block holds the read pointers for a set of sequential byte queues that share one memory. A read request names a queue. The block forms the physical address from that queue's base and its pointer, and returns the byte found there one cycle later. The pointer then moves on by one. A seek sets a pointer in a single write, using an 8-bit offset.

Queue 0 is the large queue. It spans four 256-byte regions. Its lowest region sits just below queue 1, and its upper three regions alias queues 1 to 3. When one of those covered queues is seeked, queue 0 follows it to the same offset inside that queue's region.

A seek group repositions a fixed set of queues with one write. A gated queue is paired with a controlling queue. On each read of the gated queue, the controller's current byte decides whether the gated pointer steps.

Reads form a valid/ready stream. A request is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is low only while an earlier response is still waiting for `rsp_ready`. A response that is not taken stays valid and unchanged. Seeks are plain strobes and never stall. The memory answers combinationally on two address ports: port A carries the queue's data and port B carries the controller's byte.

Top module: `qpb_bank`

## Requirements
- R1: After reset every pointer is 0, `rsp_valid` is low and `rd_ready` is high.
- R2: An accepted read of queue q returns, in the next cycle, the byte at q's pointer before the read, and q's pointer then advances by one.
- R3: The pointer of an ordinary queue wraps from 255 to 0. The pointer of queue 0 wraps from 1023 to 0.
- R4: `mem_addr_a` for a read of queue q≥1 is q*256 plus the pointer. For queue 0 it is the 10-bit pointer itself, so queue 0's regions 1 to 3 are the storage of queues 1 to 3.
- R5: A single seek (`seek_group`=0) of queue q sets q's pointer to `seek_offset`. A single seek of queue 0 sets its pointer to `seek_offset` within its lowest region.
- R6: A single seek of queue N, for N in 1..3, also sets queue 0's pointer to N*256 + `seek_offset`.
- R7: A group seek (`seek_group`=1, `seek_id` = group number) sets every member to `seek_offset`. Group 0 is {2,6,7} and group 1 is {4,5}. Queue 0 then follows the lowest-numbered covered member among 1..3, unless queue 0 is itself a member.
- R8: Queue 5 is gated by queue 4. `mem_addr_b` is queue 4's address. On each accepted read of queue 5, queue 4 always steps, and queue 5 steps only if queue 4's byte is non-zero. The response is still queue 5's byte.
- R9: When a seek and an accepted read hit the same queue in the same cycle, the read returns the byte at the old pointer and the pointer takes the seek value.
- R10: `rd_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seek_valid | input | 1 | Seek strobe |
| seek_group | input | 1 | 0: single queue, 1: seek group |
| seek_id | input | 3 | Queue number or group number |
| seek_offset | input | 8 | New pointer offset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high |
| rd_queue | input | 3 | Queue to read |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_data | output | 8 | Byte read |
| mem_addr_a | output | 11 | Address of the requested queue's byte |
| mem_data_a | input | 8 | Memory byte at `mem_addr_a` |
| mem_addr_b | output | 11 | Address of the controlling queue's byte |
| mem_data_b | input | 8 | Memory byte at `mem_addr_b` |

## Verification
The bench builds the default configuration: eight queues, a four-region large queue, groups {2,6,7} and {4,5}, and queue 5 gated by queue 4. With these values a group seek can drag the large queue through a covered member, and the gated pair can see both zero and non-zero controller bytes from the memory pattern. A seek to offset 250 brings both the 255 wrap and, through the link, the 1023 wrap within a few reads. A long pseudo-random mix then stresses seeks and reads that coincide on the same queue while responses are stalled.

// File: rtl/qpb_pkg.sv
package qpb_pkg;
  typedef enum logic {
    SEEK_SINGLE = 1'b0,
    SEEK_GROUP  = 1'b1
  } seek_kind_e;
endpackage

// File: rtl/qpb_seek_decode.sv
module qpb_seek_decode #(
  parameter int NQ = 8,
  parameter int NG = 2,
  parameter int LR = 4,
  parameter logic [NG*NQ-1:0] GROUP_MASK = '0,
  localparam int QW = $clog2(NQ),
  localparam int RW = $clog2(LR)
) (
  input  logic          seek_valid,
  input  logic          seek_group,
  input  logic [QW-1:0] seek_id,
  output logic [NQ-1:0] hit,
  output logic          link_load,
  output logic [RW-1:0] link_region
);
  import qpb_pkg::*;

  seek_kind_e kind;
  assign kind = seek_kind_e'(seek_group);

  always_comb begin
    hit = '0;
    if (seek_valid) begin
      if (kind == SEEK_SINGLE) begin
        hit[seek_id] = 1'b1;
      end else begin
        for (int g = 0; g < NG; g++) begin
          if (int'(seek_id) == g) hit = GROUP_MASK[g*NQ +: NQ];
        end
      end
    end
  end

  // lowest covered member drives the large queue unless it is hit itself
  always_comb begin
    link_load   = 1'b0;
    link_region = '0;
    if (!hit[0]) begin
      for (int i = LR - 1; i >= 1; i--) begin
        if (hit[i]) begin
          link_load   = 1'b1;
          link_region = RW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/qpb_ptr_slot.sv
module qpb_ptr_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (step)  ptr <= ptr + 1'b1;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ptr == W'($past(ptr) + 1'b1));
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr));
endmodule

// File: rtl/qpb_addr_gen.sv
module qpb_addr_gen #(
  parameter int NQ = 8,
  parameter int PW = 8,
  parameter int LR = 4,
  localparam int QW = $clog2(NQ),
  localparam int LW = PW + $clog2(LR),
  localparam int AW = QW + PW
) (
  input  logic [QW-1:0] qid,
  input  logic [LW-1:0] ptr,
  output logic [AW-1:0] addr
);
  // queue 0 base is one region below queue 1
  always_comb begin
    if (qid == '0) addr = AW'(ptr);
    else           addr = {qid, ptr[PW-1:0]};
  end
endmodule

// File: rtl/qpb_bank.sv
module qpb_bank #(
  parameter int NQ = 8,
  parameter int NG = 2,
  parameter int PW = 8,
  parameter int LR = 4,
  parameter int DW = 8,
  parameter logic [NG*NQ-1:0] GROUP_MASK = 16'b0011_0000_1100_0100,
  parameter logic [NQ-1:0]    GATE_EN    = 8'b0010_0000,
  parameter logic [NQ*8-1:0]  GATE_SRC   = 64'h0000_0400_0000_0000,
  localparam int QW = $clog2(NQ),
  localparam int RW = $clog2(LR),
  localparam int LW = PW + RW,
  localparam int AW = QW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seek_valid,
  input  logic          seek_group,
  input  logic [QW-1:0] seek_id,
  input  logic [PW-1:0] seek_offset,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [QW-1:0] rd_queue,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr_a,
  input  logic [DW-1:0] mem_data_a,
  output logic [AW-1:0] mem_addr_b,
  input  logic [DW-1:0] mem_data_b
);
  logic [NQ-1:0] hit;
  logic          link_load;
  logic [RW-1:0] link_region;
  logic [LW-1:0] ptr_all [NQ];
  logic [NQ-1:0] step;
  logic          acc, gated, step_main, step_ctrl;
  logic [QW-1:0] ctrl_id;

  qpb_seek_decode #(.NQ(NQ), .NG(NG), .LR(LR), .GROUP_MASK(GROUP_MASK)) u_dec (
    .seek_valid(seek_valid), .seek_group(seek_group), .seek_id(seek_id),
    .hit(hit), .link_load(link_load), .link_region(link_region)
  );

  assign rd_ready  = !rsp_valid || rsp_ready;
  assign acc       = rd_valid && rd_ready;
  assign gated     = GATE_EN[rd_queue];
  assign ctrl_id   = GATE_SRC[int'(rd_queue)*8 +: QW];
  assign step_main = acc && (!gated || (mem_data_b != '0));
  assign step_ctrl = acc && gated;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      step[i] = (step_main && (int'(rd_queue) == i)) ||
                (step_ctrl && (int'(ctrl_id) == i));
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_slot
    if (i == 0) begin : g_large
      logic [LW-1:0] lval;
      assign lval = hit[0] ? {RW'(0), seek_offset} : {link_region, seek_offset};
      qpb_ptr_slot #(.W(LW)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(hit[0] || link_load), .load_val(lval),
        .step(step[0]), .ptr(ptr_all[0])
      );
    end else begin : g_small
      logic [PW-1:0] p;
      qpb_ptr_slot #(.W(PW)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(hit[i]), .load_val(seek_offset),
        .step(step[i]), .ptr(p)
      );
      assign ptr_all[i] = {RW'(0), p};
    end
  end

  qpb_addr_gen #(.NQ(NQ), .PW(PW), .LR(LR)) u_addr_a (
    .qid(rd_queue), .ptr(ptr_all[rd_queue]), .addr(mem_addr_a)
  );
  qpb_addr_gen #(.NQ(NQ), .PW(PW), .LR(LR)) u_addr_b (
    .qid(ctrl_id), .ptr(ptr_all[ctrl_id]), .addr(mem_addr_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem_data_a;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  a_r6_link: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_valid && !seek_group && seek_id != '0 && int'(seek_id) < LR)
      |=> ptr_all[0] == {$past(seek_id[RW-1:0]), $past(seek_offset)});
  a_r2_resp: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
endmodule

// File: tb/qpb_bank_tb.sv
module qpb_bank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic seek_valid = 0, seek_group = 0, rd_valid = 0, rsp_ready = 1;
  logic [2:0] seek_id = 0, rd_queue = 0;
  logic [7:0] seek_offset = 0;
  logic rd_ready, rsp_valid;
  logic [7:0] rsp_data, mem_data_a, mem_data_b;
  logic [10:0] mem_addr_a, mem_addr_b;
  logic [7:0] mem [2048];

  int tests = 0, fails = 0;
  int mp[8], np[8];
  bit mv, nv;
  int md, nd;
  int lfsr = 32'h1d3a;

  always #2 clk = ~clk;

  assign mem_data_a = mem[mem_addr_a];
  assign mem_data_b = mem[mem_addr_b];

  qpb_bank u_dut (
    .clk(clk), .rst_n(rst_n), .seek_valid(seek_valid), .seek_group(seek_group),
    .seek_id(seek_id), .seek_offset(seek_offset), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_queue(rd_queue), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_addr_a(mem_addr_a),
    .mem_data_a(mem_data_a), .mem_addr_b(mem_addr_b), .mem_data_b(mem_data_b)
  );

  function automatic int qbase(int q);
    return q * 256;
  endfunction
  function automatic int span(int q);
    return (q == 0) ? 1024 : 256;
  endfunction
  function automatic bit member(int g, int q);
    if (g == 0) return (q == 2 || q == 6 || q == 7);
    if (g == 1) return (q == 4 || q == 5);
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(string req, bit sv, bit sg, int sid, int soff,
                     bit rv, int rq, bit rr);
    bit mrdy, acc, gated, hit[8], q0hit;
    int cb;
    @(negedge clk);
    seek_valid = sv; seek_group = sg; seek_id = 3'(sid); seek_offset = 8'(soff);
    rd_valid = rv; rd_queue = 3'(rq); rsp_ready = rr;
    #1;
    mrdy = !mv || rr;
    chk({req, " R10 rd_ready"}, int'(rd_ready), int'(mrdy));
    acc = rv && mrdy;
    if (rv) chk({req, " R4 address"}, int'(mem_addr_a), qbase(rq) + mp[rq]);
    np = mp; nv = mv; nd = md;
    if (acc) begin
      nv = 1; nd = int'(mem[qbase(rq) + mp[rq]]);
      gated = (rq == 5);
      if (gated) begin
        chk({req, " R8 ctrl address"}, int'(mem_addr_b), qbase(4) + mp[4]);
        cb = int'(mem[qbase(4) + mp[4]]);
        np[4] = (mp[4] + 1) % span(4);
        if (cb != 0) np[5] = (mp[5] + 1) % span(5);
      end else begin
        np[rq] = (mp[rq] + 1) % span(rq);
      end
    end else if (rr) nv = 0;
    if (sv) begin
      for (int i = 0; i < 8; i++) hit[i] = sg ? member(sid, i) : (i == sid);
      for (int i = 0; i < 8; i++) if (hit[i]) np[i] = soff;
      q0hit = hit[0];
      if (!q0hit) begin
        for (int i = 3; i >= 1; i--) if (hit[i]) np[0] = i * 256 + soff;
      end
    end
    @(posedge clk);
    mp = np; mv = nv; md = nd;
    #1;
    chk({req, " R10 rsp_valid"}, int'(rsp_valid), int'(mv));
    if (mv) chk({req, " R2 rsp_data"}, int'(rsp_data), md);
  endtask

  task automatic rd(string req, int q, int n);
    for (int k = 0; k < n; k++) cyc(req, 0, 0, 0, 0, 1, q, 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2048; a++) begin
      if (a >= 1024 && a < 1280) mem[a] = (((a - 1024) >> 1) & 1) != 0 ? 8'h5a : 8'h00;
      else mem[a] = 8'((a * 37 + (a >> 8) * 11 + 1) & 255);
    end
    for (int i = 0; i < 8; i++) mp[i] = 0;
    mv = 0; md = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 rd_ready", int'(rd_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    for (int q = 0; q < 8; q++) cyc("R1 zero pointer", 0, 0, 0, 0, 1, q, 1);
    rd("R2 sequential", 1, 4);
    cyc("R10 stall", 0, 0, 0, 0, 1, 2, 0);
    cyc("R10 stall", 0, 0, 0, 0, 1, 2, 0);
    cyc("R10 stall", 0, 0, 0, 0, 1, 2, 0);
    cyc("R10 release", 0, 0, 0, 0, 1, 2, 1);
    cyc("R10 drain", 0, 0, 0, 0, 0, 0, 1);
    cyc("R5 R6 seek q3", 1, 0, 3, 250, 0, 0, 1);
    rd("R3 small wrap", 3, 8);
    rd("R3 R6 large wrap", 0, 8);
    cyc("R5 seek q0", 1, 0, 0, 7, 0, 0, 1);
    rd("R5 q0 region0", 0, 2);
    cyc("R6 seek q1", 1, 0, 1, 40, 0, 0, 1);
    rd("R6 q0 follows q1", 0, 2);
    cyc("R7 group0", 1, 1, 0, 100, 0, 0, 1);
    rd("R7 q2", 2, 1); rd("R7 q6", 6, 1); rd("R7 q7", 7, 1); rd("R7 q0 link", 0, 1);
    cyc("R7 group1", 1, 1, 1, 0, 0, 0, 1);
    rd("R8 gated", 5, 8);
    rd("R8 controller", 4, 2);
    cyc("R9 seek+read", 1, 0, 6, 9, 1, 6, 1);
    rd("R9 after", 6, 2);
    for (int k = 0; k < 600; k++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1);
      lfsr = lfsr & 32'hffff;
      cyc("R2 R8 R9 mix", (lfsr & 7) == 0, (lfsr & 8) != 0,
          (lfsr & 8) != 0 ? ((lfsr >> 4) & 1) : ((lfsr >> 4) & 7),
          (lfsr >> 7) & 255, (lfsr & 16) != 0 || (lfsr & 32) != 0,
          (lfsr >> 9) & 7, (lfsr & 64) != 0 || (lfsr & 2) != 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule